// File: doc/BRIEF.md
# Configurable Sample Filter Core

A streaming filter stage for signed 16-bit converter samples. Each accepted sample passes through one of three datapaths: a straight pass, a nine-tap (8th-order) FIR, or a 4th-order recursive (IIR) section. It then gets a power-of-two gain, an optional clamp to the 16-bit range, and delivery to one of two places. All of this is set by a single control word. Nine signed Q1.15 coefficients live in local registers. Products sum into a 40-bit accumulator.

Samples come either from a converter port (a valid strobe with data) or from bus writes to an input buffer register. Results always land in a bus-readable output buffer. When the FIFO destination is chosen, each result also goes out as a one-cycle strobe on a result port. An output interrupt pulses for every new result. A level error interrupt stays high while any of five sticky error flags is set. Software clears those flags by writing ones to them.

Top module: `sample_filter_core`

## Requirements
- R1: Control bits [1:0] select the datapath: 00 straight pass, 10 FIR, 01 IIR, 11 same as 00. In straight pass, a sample accepted at one clock edge shows up in the output buffer at the next edge, multiplied by the gain.
- R2: FIR mode computes y = sum over k=0..8 of c[k]*x[n-k]. Coefficient c[k] is the signed Q1.15 register at bus address 16+k. The sum is shifted right by 15 and then by the gain.
- R3: IIR mode computes y = sum over k=0..4 of c[k]*x[n-k] plus the sum over j=1..4 of c[4+j]*y[n-j], where y[n-j] are the 16-bit results already written. Status bit 1 (divergence) is set when the IIR accumulator falls outside the signed 32-bit range.
- R4: Control bits [3:2] set the gain: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 16. The result equals the accumulator arithmetic-shifted right by 15, 13, 12 or 11.
- R5: With control bit 4 set, an out-of-range result clamps to 0x7FFF or 0x8000 and sets status bit 2. With it clear, the low 16 bits wrap and status bit 0 (overflow) is set.
- R6: With control bit 5 set, samples from both sources are ignored: no result appears and the input buffer (address 2) keeps its value.
- R7: Control bits [7:6] route data. Bit 7 picks the source: 0 means converter port, 1 means bus writes to address 2; a bus write to address 2 is ignored while the converter is the source. Values 00 and 11 send each result out as a one-cycle `res_valid` strobe; 01 and 10 do not. The output buffer (address 3) is updated in every case.
- R8: With control bit 8 set, `irq_out` pulses for one cycle with each new result, for either destination. With it clear, `irq_out` stays low.
- R9: With control bit 9 set, `irq_err` is high while any status flag is set. With it clear, `irq_err` is low.
- R10: Status flags (address 1, bits [4:0]) are sticky. Writing 1 to a bit clears it; writing 0 leaves it unchanged.
- R11: Status bit 4 (input overrun) is set when a sample is accepted in the cycle right after another accepted sample. Both samples are still filtered.
- R12: Status bit 3 (output overrun) is set when, with destination 01 or 10, a new result is written while the previous one has not been read. A read is a `bus_rd` strobe at address 3.
- R13: A control write that changes bits [1:0] clears all input and output history.
- R14: After reset, control, status and both buffers read 0, and `res_valid`, `irq_out` and `irq_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (marks the output buffer as read) |
| bus_addr | input | 5 | Register address: 0 control, 1 status, 2 input, 3 output, 16..24 coefficients |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| adc_valid | input | 1 | Converter sample strobe |
| adc_data | input | 16 | Converter sample, signed |
| res_valid | output | 1 | Result strobe toward the result FIFO |
| res_data | output | 16 | Result value toward the result FIFO |
| irq_out | output | 1 | New-result interrupt pulse |
| irq_err | output | 1 | Error interrupt level |

## Verification
The bench uses the default parameters: 16-bit samples and coefficients, a 40-bit accumulator, nine taps split five forward and four feedback, and a 32-bit divergence bound. With these values, three full-scale samples against full-scale forward coefficients push the accumulator past 32 bits while it still fits in 40. This makes the divergence, clamp and wrap cases reachable in a few cycles. A scoreboard model in the bench computes every result from the coefficients and history it tracks itself, including the history clearing on a type change.

// File: rtl/sample_filter_core.sv
module sample_filter_core #(
  parameter int DW    = 16,
  parameter int AW    = 5,
  parameter int ACC_W = 40,
  parameter int FRAC  = 15,
  parameter int DIV_W = 32,
  parameter int NTAP  = 9,
  parameter int NB    = 5,
  parameter int CBASE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          adc_valid,
  input  logic [DW-1:0] adc_data,
  output logic          res_valid,
  output logic [DW-1:0] res_data,
  output logic          irq_out,
  output logic          irq_err
);
  localparam int NX = NTAP - 1;
  localparam int NA = NTAP - NB;
  localparam int CW = 10;
  localparam int EW = 5;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_IN   = AW'(2);
  localparam logic [AW-1:0] A_OUT  = AW'(3);
  localparam logic signed [ACC_W-1:0] YMAX = {{(ACC_W-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] YMIN = ~YMAX;
  localparam logic signed [ACC_W-1:0] DMAX = {{(ACC_W-DIV_W+1){1'b0}}, {(DIV_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] DMIN = ~DMAX;

  logic [CW-1:0] ctrl;
  logic [EW-1:0] err;
  logic signed [DW-1:0] in_buf, out_buf;
  logic in_pend, res_q, fifo_q, out_full;
  logic signed [DW-1:0] coef [NTAP];
  logic signed [DW-1:0] xh [NX];
  logic signed [DW-1:0] yh [NA];

  wire [1:0] ftype   = ctrl[1:0];
  wire [1:0] scale   = ctrl[3:2];
  wire       sat_en  = ctrl[4];
  wire       in_dis  = ctrl[5];
  wire       src_bus = ctrl[7];
  wire       dest_fifo = ctrl[7] == ctrl[6];
  wire       oden    = ctrl[8];
  wire       erren   = ctrl[9];

  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire wr_stat = bus_wr && bus_addr == A_STAT;
  wire wr_in   = bus_wr && bus_addr == A_IN;
  wire rd_out  = bus_rd && bus_addr == A_OUT;
  wire type_chg = wr_ctrl && bus_wdata[1:0] != ftype;
  wire accept  = !in_dis && (src_bus ? wr_in : adc_valid);
  wire [DW-1:0] smp = src_bus ? bus_wdata : adc_data;

  logic signed [ACC_W-1:0] acc, ext, shifted;
  logic [2:0] sh;
  logic hi, lo, div_ev;
  logic [DW-1:0] res16;

  always_comb begin
    ext = in_buf;
    acc = '0;
    case (ftype)
      2'b10: begin
        acc = coef[0] * in_buf;
        for (int k = 1; k < NTAP; k++) acc = acc + coef[k] * xh[k-1];
      end
      2'b01: begin
        acc = coef[0] * in_buf;
        for (int k = 1; k < NB; k++) acc = acc + coef[k] * xh[k-1];
        for (int j = 0; j < NA; j++) acc = acc + coef[NB+j] * yh[j];
      end
      default: acc = ext <<< FRAC;
    endcase
  end

  assign sh      = (scale == 2'b00) ? 3'd0 : {1'b0, scale} + 3'd1;
  assign shifted = acc >>> (FRAC - int'(sh));
  assign hi      = shifted > YMAX;
  assign lo      = shifted < YMIN;
  assign div_ev  = ftype == 2'b01 && (acc > DMAX || acc < DMIN);
  assign res16   = (sat_en && hi) ? YMAX[DW-1:0] :
                   (sat_en && lo) ? YMIN[DW-1:0] : shifted[DW-1:0];

  wire [EW-1:0] set_ev = {
    accept && in_pend,
    in_pend && !dest_fifo && out_full && !rd_out,
    in_pend && sat_en && (hi || lo),
    in_pend && div_ev,
    in_pend && !sat_en && (hi || lo)
  };
  wire [EW-1:0] clr_mask = wr_stat ? bus_wdata[EW-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      err      <= '0;
      in_buf   <= '0;
      out_buf  <= '0;
      in_pend  <= 1'b0;
      res_q    <= 1'b0;
      fifo_q   <= 1'b0;
      out_full <= 1'b0;
      for (int k = 0; k < NTAP; k++) coef[k] <= '0;
      for (int k = 0; k < NX; k++) xh[k] <= '0;
      for (int j = 0; j < NA; j++) yh[j] <= '0;
    end else begin
      if (wr_ctrl) ctrl <= bus_wdata[CW-1:0];
      for (int k = 0; k < NTAP; k++)
        if (bus_wr && bus_addr == AW'(CBASE + k)) coef[k] <= bus_wdata;
      if (accept) in_buf <= smp;
      in_pend <= accept;
      res_q   <= in_pend;
      fifo_q  <= in_pend && dest_fifo;
      if (in_pend) out_buf <= res16;
      if (in_pend && !dest_fifo) out_full <= 1'b1;
      else if (rd_out) out_full <= 1'b0;
      if (type_chg) begin
        for (int k = 0; k < NX; k++) xh[k] <= '0;
        for (int j = 0; j < NA; j++) yh[j] <= '0;
      end else if (in_pend) begin
        xh[0] <= in_buf;
        for (int k = 1; k < NX; k++) xh[k] <= xh[k-1];
        yh[0] <= res16;
        for (int j = 1; j < NA; j++) yh[j] <= yh[j-1];
      end
      err <= (err & ~clr_mask) | set_ev;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = DW'(ctrl);
      A_STAT:  bus_rdata = DW'(err);
      A_IN:    bus_rdata = in_buf;
      A_OUT:   bus_rdata = out_buf;
      default: for (int k = 0; k < NTAP; k++)
                 if (bus_addr == AW'(CBASE + k)) bus_rdata = coef[k];
    endcase
  end

  assign res_valid = fifo_q;
  assign res_data  = out_buf;
  assign irq_out   = res_q && oden;
  assign irq_err   = erren && |err;
endmodule

module sample_filter_core_chk #(
  parameter int EW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_dis,
  input logic          in_pend,
  input logic          accept,
  input logic [EW-1:0] err,
  input logic          wr_stat,
  input logic          wr_ctrl,
  input logic          res_valid,
  input logic          dest_fifo,
  input logic          irq_out,
  input logic          irq_err
);
  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_dis |=> !in_pend);
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((err & $past(err)) == $past(err)));
  p_fifo_dest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(dest_fifo));
  p_irq_after_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(in_pend));
  p_irq_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_err && !wr_stat && !wr_ctrl) |=> irq_err);
  p_in_overrun_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_pend) |=> err[4]);
endmodule

bind sample_filter_core sample_filter_core_chk #(.EW(5)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_dis(in_dis), .in_pend(in_pend),
  .accept(accept), .err(err), .wr_stat(wr_stat), .wr_ctrl(wr_ctrl),
  .res_valid(res_valid), .dest_fifo(dest_fifo), .irq_out(irq_out),
  .irq_err(irq_err)
);

// File: tb/tb_sample_filter_core.sv
`timescale 1ns/1ps
module tb_sample_filter_core;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [4:0] bus_addr = 5'd3;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic adc_valid = 0;
  logic [15:0] adc_data = '0;
  logic res_valid, irq_out, irq_err;
  logic [15:0] res_data;

  always #10 clk = ~clk;

  sample_filter_core dut (.*);

  int n_chk = 0, n_fail = 0, irq_cnt = 0, fifo_cnt = 0;
  logic [15:0] exp_q[$];
  logic signed [15:0] m_c [9];
  logic signed [15:0] m_x [8];
  logic signed [15:0] m_y [4];
  logic [1:0] m_type = 0, m_scale = 0, m_route = 0;
  logic m_sat = 0;
  logic [4:0] exp_err = 0;

  task automatic chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] model(input logic signed [15:0] x);
    longint acc, s;
    int sh;
    logic [15:0] y;
    acc = 0;
    if (m_type == 2'b10) begin
      acc = longint'(m_c[0]) * longint'(x);
      for (int k = 1; k < 9; k++) acc += longint'(m_c[k]) * longint'(m_x[k-1]);
    end else if (m_type == 2'b01) begin
      acc = longint'(m_c[0]) * longint'(x);
      for (int k = 1; k < 5; k++) acc += longint'(m_c[k]) * longint'(m_x[k-1]);
      for (int j = 0; j < 4; j++) acc += longint'(m_c[5+j]) * longint'(m_y[j]);
      if (acc > 64'sd2147483647 || acc < -64'sd2147483648) exp_err[1] = 1;
    end else acc = longint'(x) * 32768;
    sh = (m_scale == 0) ? 0 : int'(m_scale) + 1;
    s = acc >>> (15 - sh);
    if (s > 32767 || s < -32768) begin
      if (m_sat) begin y = (s > 0) ? 16'h7FFF : 16'h8000; exp_err[2] = 1; end
      else begin y = s[15:0]; exp_err[0] = 1; end
    end else y = s[15:0];
    for (int k = 7; k > 0; k--) m_x[k] = m_x[k-1];
    m_x[0] = x;
    for (int j = 3; j > 0; j--) m_y[j] = m_y[j-1];
    m_y[0] = y;
    return y;
  endfunction

  initial begin
    forever begin
      @(posedge clk); #5;
      if (rst_n && (irq_out || res_valid)) begin
        logic [15:0] got, e;
        if (irq_out) irq_cnt++;
        if (res_valid) fifo_cnt++;
        got = res_valid ? res_data : bus_rdata;
        chk(res_valid == (m_route[1] == m_route[0]), "R7 destination strobe", res_valid, m_route[1] == m_route[0]);
        if (exp_q.size() == 0) chk(0, "R6 unexpected result", got, 0);
        else begin
          e = exp_q.pop_front();
          chk(got == e, "R1/R2/R3/R4/R5 result value", got, e);
        end
      end
    end
  end

  task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_addr = 5'd3;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; #5; d = bus_rdata; bus_addr = 5'd3;
  endtask

  task automatic read_strobe();
    @(negedge clk); bus_rd = 1; bus_addr = 5'd3;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic set_coef(input int k, input logic [15:0] v);
    m_c[k] = v;
    bus_write(5'(16 + k), v);
  endtask

  task automatic set_ctrl(input logic [1:0] t, input logic [1:0] sc, input logic sat,
                          input logic idis, input logic [1:0] rt, input logic oden, input logic erren);
    if (t != m_type) begin
      for (int k = 0; k < 8; k++) m_x[k] = 0;
      for (int j = 0; j < 4; j++) m_y[j] = 0;
    end
    m_type = t; m_scale = sc; m_sat = sat; m_route = rt;
    bus_write(5'd0, {6'd0, erren, oden, rt, idis, sat, sc, t});
  endtask

  task automatic drive(input logic [15:0] x);
    if (m_route[1]) begin bus_wr = 1; bus_addr = 5'd2; bus_wdata = x; end
    else begin adc_valid = 1; adc_data = x; end
  endtask

  task automatic undrive();
    bus_wr = 0; bus_addr = 5'd3; adc_valid = 0;
  endtask

  task automatic send(input logic [15:0] x);
    @(negedge clk); exp_q.push_back(model(x)); drive(x);
    @(negedge clk); undrive();
  endtask

  task automatic send2(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk); exp_q.push_back(model(a)); drive(a);
    @(negedge clk); exp_q.push_back(model(b)); drive(b);
    @(negedge clk); undrive();
  endtask

  task automatic drain(input string tag);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic check_status(input string tag);
    logic [15:0] d;
    bus_read(5'd1, d);
    chk(d == {11'd0, exp_err}, tag, d, exp_err);
  endtask

  task automatic clear_flags();
    bus_write(5'd1, 16'h001F);
    exp_err = 0;
  endtask

  task automatic run_all();
    logic [15:0] d, keep;
    int ic;
    for (int k = 0; k < 9; k++) m_c[k] = 0;
    for (int k = 0; k < 8; k++) m_x[k] = 0;
    for (int j = 0; j < 4; j++) m_y[j] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R14 reset state
    for (int a = 0; a < 4; a++) begin
      bus_read(5'(a), d);
      chk(d == 0, "R14 register after reset", d, 0);
    end
    chk(!res_valid && !irq_out && !irq_err, "R14 outputs after reset", {res_valid, irq_out, irq_err}, 0);

    // R1 straight pass, converter to FIFO
    set_ctrl(2'b00, 2'b00, 0, 0, 2'b00, 1, 0);
    send(16'h1234); send(16'hFFFB); send(16'h8000);
    drain("R1 straight pass drained");
    ic = irq_cnt;
    // R4 gains
    set_ctrl(2'b00, 2'b01, 0, 0, 2'b00, 1, 0); send(16'h0100);
    set_ctrl(2'b00, 2'b10, 0, 0, 2'b00, 1, 0); send(16'h0100);
    set_ctrl(2'b00, 2'b11, 0, 0, 2'b00, 1, 0); send(16'hFF00);
    drain("R4 gain results drained");
    chk(irq_cnt == ic + 3, "R8 one pulse per result", irq_cnt - ic, 3);

    // R5 clamp and wrap
    set_ctrl(2'b00, 2'b11, 1, 0, 2'b00, 1, 0);
    send(16'h1000); send(16'hF000);
    drain("R5 clamp results drained");
    check_status("R5 saturation flag bit2");
    bus_write(5'd1, 16'h0000);
    check_status("R10 write zero keeps flag");
    clear_flags();
    check_status("R10 write one clears flag");
    set_ctrl(2'b00, 2'b11, 0, 0, 2'b00, 1, 0);
    send(16'h1000);
    drain("R5 wrap result drained");
    check_status("R5 overflow flag bit0");
    clear_flags();

    // R1 reserved type behaves as straight pass
    set_ctrl(2'b11, 2'b00, 0, 0, 2'b00, 1, 0);
    send(16'h0ABC);
    drain("R1 reserved type drained");

    // R2 FIR, bus input to FIFO
    set_coef(0, 16'h4000); set_coef(1, 16'h2000); set_coef(2, 16'h0100);
    set_coef(3, 16'hFF00); set_coef(4, 16'h1000); set_coef(5, 16'h0800);
    set_coef(6, 16'h0400); set_coef(7, 16'h0200); set_coef(8, 16'hF000);
    set_ctrl(2'b10, 2'b00, 1, 0, 2'b11, 1, 0);
    for (int i = 0; i < 12; i++) send(16'((i * 16'h0931) ^ 16'h5A5A));
    drain("R2 FIR results drained");
    bus_read(5'd2, d);
    chk(d == 16'((11 * 16'h0931) ^ 16'h5A5A), "R7 bus source fills input buffer", d, 16'((11 * 16'h0931) ^ 16'h5A5A));
    clear_flags();

    // R7 bus writes ignored while converter is the source
    set_ctrl(2'b10, 2'b00, 1, 0, 2'b00, 1, 0);
    bus_read(5'd2, keep);
    bus_write(5'd2, 16'h7777);
    drain("R7 ignored bus sample gives no result");
    bus_read(5'd2, d);
    chk(d == keep, "R7 input buffer unchanged", d, keep);

    // R13 history cleared on type change
    for (int k = 0; k < 9; k++) set_coef(k, 16'h0000);
    set_coef(1, 16'h4000);
    set_ctrl(2'b10, 2'b00, 0, 0, 2'b00, 1, 0);
    send(16'h2000); send(16'h0000);
    set_ctrl(2'b00, 2'b00, 0, 0, 2'b00, 1, 0);
    set_ctrl(2'b10, 2'b00, 0, 0, 2'b00, 1, 0);
    send(16'h0000);
    drain("R13 results drained");
    chk(m_y[0] == 0, "R13 expected zero after clear", m_y[0], 0);

    // R3 IIR impulse response
    set_coef(0, 16'h4000); set_coef(1, 16'h0000); set_coef(5, 16'h4000);
    set_coef(6, 16'hE000);
    set_ctrl(2'b01, 2'b00, 0, 0, 2'b11, 1, 0);
    send(16'h4000);
    for (int i = 0; i < 6; i++) send(16'h0000);
    drain("R3 IIR results drained");
    check_status("R3 no flags on stable section");
    // R3 divergence
    for (int k = 0; k < 5; k++) set_coef(k, 16'h7FFF);
    for (int k = 5; k < 9; k++) set_coef(k, 16'h0000);
    set_ctrl(2'b10, 2'b00, 1, 0, 2'b11, 1, 1);
    set_ctrl(2'b01, 2'b00, 1, 0, 2'b11, 1, 1);
    send(16'h7FFF); send(16'h7FFF); send(16'h7FFF);
    drain("R3 divergence results drained");
    check_status("R3 divergence flag bit1");
    chk(irq_err == 1, "R9 error interrupt high", irq_err, 1);
    set_ctrl(2'b01, 2'b00, 1, 0, 2'b11, 1, 0);
    @(negedge clk);
    chk(irq_err == 0, "R9 error interrupt masked", irq_err, 0);
    set_ctrl(2'b01, 2'b00, 1, 0, 2'b11, 1, 1);
    clear_flags();
    @(negedge clk);
    chk(irq_err == 0, "R9 error interrupt after clear", irq_err, 0);

    // R6 input disable, both sources
    set_ctrl(2'b00, 2'b00, 0, 1, 2'b00, 1, 0);
    bus_read(5'd2, keep);
    @(negedge clk); adc_valid = 1; adc_data = 16'h5555;
    @(negedge clk); adc_valid = 0;
    set_ctrl(2'b00, 2'b00, 0, 1, 2'b10, 1, 0);
    bus_write(5'd2, 16'h6666);
    drain("R6 no result while disabled");
    bus_read(5'd2, d);
    chk(d == keep, "R6 input buffer unchanged", d, keep);

    // R11 input overrun
    set_ctrl(2'b00, 2'b00, 0, 0, 2'b00, 1, 0);
    send2(16'h0101, 16'h0202);
    drain("R11 both samples filtered");
    exp_err[4] = 1;
    check_status("R11 input overrun flag bit4");
    clear_flags();

    // R12 output overrun, converter to output buffer
    set_ctrl(2'b00, 2'b00, 0, 0, 2'b01, 1, 0);
    ic = fifo_cnt;
    send(16'h0303); send(16'h0404);
    drain("R12 buffer results drained");
    exp_err[3] = 1;
    check_status("R12 output overrun flag bit3");
    clear_flags();
    read_strobe();
    send(16'h0505); drain("R12 result drained");
    read_strobe();
    send(16'h0606); drain("R12 result drained");
    check_status("R12 no overrun when read");
    chk(fifo_cnt == ic, "R7 no FIFO strobe for buffer destination", fifo_cnt - ic, 0);
    bus_read(5'd3, d);
    chk(d == 16'h0606, "R7 output buffer holds result", d, 16'h0606);

    // R8 output interrupt disabled
    set_ctrl(2'b00, 2'b00, 0, 0, 2'b00, 0, 0);
    ic = irq_cnt;
    send(16'h0707);
    drain("R8 result drained");
    chk(irq_cnt == ic, "R8 no pulse when disabled", irq_cnt - ic, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule